// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo PCM stream carried on three lines (bit clock, word clock and serial data) and turns it into parallel left and right samples. Each sample comes with a one-cycle valid pulse. All three serial lines are sampled on the system clock. A bit is taken at each rising edge of the bit clock, seen as a low-to-high change between two system-clock samples. A word-clock change marks the boundary between channel slots.

A two-bit format code picks one of four framings: left-justified MSB-first, right-justified MSB-first, right-justified LSB-first, or I2S. A two-bit length code sets the word length to 16, 20 or 24 bits, and it is used only by the right-justified MSB-first framing. The fourth length code is reserved; with that framing it raises an error flag and forces zero samples. A mute input forces every sample captured while it is high to zero.

Top module: `serial_audio_rx`

## Requirements
- R1: During and right after synchronous reset, both sample outputs are zero and both valid pulses and the error flag are low.
- R2: Format code 0 (left-justified): the first 24 bits after a word-clock change form the sample, MSB first and MSB-aligned. Shorter words therefore appear in the upper bits. High word clock is the left channel.
- R3: Format code 1 (right-justified MSB-first): the last W bits before the next word-clock change form the sample, with the last bit as LSB. W is 16, 20 or 24 for length codes 0, 1 and 2. The result is sign-extended to 24 bits. High word clock is left.
- R4: Format code 2 (right-justified LSB-first): the last 24 bits before the next word-clock change form the sample. The earliest of them is the LSB and the last is the MSB. High word clock is left.
- R5: Format code 3 (I2S): the MSB is the bit one bit-clock after the word-clock change. The word is taken MSB-aligned as in R2. Low word clock is the left channel.
- R6: Outside format 1 the length code has no effect. With code 3 (reserved) the samples are normal and the error flag stays low.
- R7: With format 1 and length code 3, the error flag is high from the clock edge after the codes are applied, and every sample delivered is zero.
- R8: A sample whose slot ends while mute is high is delivered as zero.
- R9: Each complete slot gives exactly one valid pulse on its own channel. The partial slot running when reception starts is discarded.
- R10: A valid pulse and its sample appear on the third system-clock rising edge, counting from the first edge that sees the bit clock high for the first bit of the following slot.
- R11: The left and right valid pulses are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| wclk | input | 1 | Word clock, selects the channel slot |
| sdata | input | 1 | Serial data line |
| fmt | input | 2 | Framing code: 0 left-justified, 1 right-justified MSB-first, 2 right-justified LSB-first, 3 I2S |
| wlen | input | 2 | Word length code: 0=16, 1=20, 2=24, 3 reserved |
| mute | input | 1 | Zero-mute control |
| left_data | output | 24 | Last left sample |
| left_valid | output | 1 | One-cycle strobe for left_data |
| right_data | output | 24 | Last right sample |
| right_valid | output | 1 | One-cycle strobe for right_data |
| len_err | output | 1 | Reserved word length in right-justified MSB-first mode |

## Verification
A slot's sample and valid pulse come three system-clock edges after the bit-clock rise that carries the first bit of the next slot. This is one edge for bit capture, one for the slot boundary and one for output formatting. The error flag follows the codes after one edge. The bench holds each bit-clock phase for four system clocks, so no new bit arrives while a result is in flight. It samples the outputs on the falling clock edge. It records the cycle number of every bit-clock rise it drives and checks that the valid pulse falls exactly three cycles later. Sample values are compared only after the stream, including two bits of the next slot, has been sent.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    localparam int SAMPLE_W = 24;
    localparam int SLOT_CNT_W = 6;

    typedef enum logic [1:0] {
        FMT_LEFT_J  = 2'd0,
        FMT_RIGHT_M = 2'd1,
        FMT_RIGHT_L = 2'd2,
        FMT_I2S     = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        LEN_16   = 2'd0,
        LEN_20   = 2'd1,
        LEN_24   = 2'd2,
        LEN_RSVD = 2'd3
    } word_len_e;

    typedef struct packed {
        logic                is_left;
        logic [SAMPLE_W-1:0] head;
        logic [SAMPLE_W-1:0] tail;
    } slot_word_t;

    function automatic logic [SAMPLE_W-1:0] bit_rev(input logic [SAMPLE_W-1:0] v);
        logic [SAMPLE_W-1:0] r;
        for (int k = 0; k < SAMPLE_W; k++) r[k] = v[SAMPLE_W-1-k];
        return r;
    endfunction

    function automatic logic [SAMPLE_W-1:0] assemble(input frame_fmt_e f, input word_len_e l,
                                                     input slot_word_t s);
        logic [SAMPLE_W-1:0] o;
        case (f)
            FMT_RIGHT_M: begin
                case (l)
                    LEN_16:  o = {{(SAMPLE_W-16){s.tail[15]}}, s.tail[15:0]};
                    LEN_20:  o = {{(SAMPLE_W-20){s.tail[19]}}, s.tail[19:0]};
                    LEN_24:  o = s.tail;
                    default: o = '0;
                endcase
            end
            FMT_RIGHT_L: o = bit_rev(s.tail);
            default:     o = s.head;
        endcase
        return o;
    endfunction
endpackage

// File: rtl/sarx_bit_front.sv
module sarx_bit_front (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic wclk,
    input  logic sdata,
    output logic bit_stb,
    output logic bit_val,
    output logic bit_lr
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
            bit_lr  <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            bit_stb <= bclk & ~bclk_q;
            if (bclk & ~bclk_q) begin
                bit_val <= sdata;
                bit_lr  <= wclk;
            end
        end
    end

    // a strobe needs a low sample before it, so two in a row cannot occur (R10)
    assert_stb_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/sarx_slot_acc.sv
module sarx_slot_acc
    import sarx_pkg::*;
#(
    parameter int OUT_W = SAMPLE_W,
    parameter int CNT_W = SLOT_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       i2s_mode,
    input  logic       bit_stb,
    input  logic       bit_val,
    input  logic       bit_lr,
    output logic       fin_stb,
    output slot_word_t fin_word
);
    localparam int IW = $clog2(OUT_W);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             started, armed, lr_d1, prev_eff;
    logic [CNT_W-1:0] cnt;
    logic [OUT_W-1:0] head, tail;
    logic             eff, boundary;
    logic [IW-1:0]    wr_idx;

    always_comb begin
        eff      = i2s_mode ? lr_d1 : bit_lr;
        boundary = started && (eff != prev_eff);
        wr_idx   = IW'(OUT_W-1) - IW'(cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started  <= 1'b0;
            armed    <= 1'b0;
            lr_d1    <= 1'b0;
            prev_eff <= 1'b0;
            cnt      <= '0;
            head     <= '0;
            tail     <= '0;
            fin_stb  <= 1'b0;
            fin_word <= '0;
        end else begin
            fin_stb <= 1'b0;
            if (bit_stb) begin
                lr_d1 <= bit_lr;
                tail  <= {tail[OUT_W-2:0], bit_val};
                if (!started) begin
                    started  <= 1'b1;
                    prev_eff <= bit_lr;
                    cnt      <= CNT_MAX;
                end else if (boundary) begin
                    prev_eff <= eff;
                    armed    <= 1'b1;
                    fin_stb  <= armed;
                    fin_word.is_left <= i2s_mode ? ~prev_eff : prev_eff;
                    fin_word.head    <= head;
                    fin_word.tail    <= tail;
                    head     <= {bit_val, {(OUT_W-1){1'b0}}};
                    cnt      <= CNT_W'(1);
                end else begin
                    if (cnt < CNT_W'(OUT_W)) head[wr_idx] <= bit_val;
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // a finished slot always follows a captured bit (R10)
    assert_fin_after_bit_R10: assert property (@(posedge clk) disable iff (rst)
        fin_stb |-> $past(bit_stb));
    // at most one slot completes per bit (R9)
    assert_single_fin_R9: assert property (@(posedge clk) disable iff (rst)
        fin_stb |=> !fin_stb);
endmodule

// File: rtl/sarx_out_stage.sv
module sarx_out_stage
    import sarx_pkg::*;
#(
    parameter int OUT_W = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_fmt_e       fmt,
    input  word_len_e        wlen,
    input  logic             mute,
    input  logic             fin_stb,
    input  slot_word_t       fin_word,
    output logic [OUT_W-1:0] left_data,
    output logic             left_valid,
    output logic [OUT_W-1:0] right_data,
    output logic             right_valid,
    output logic             len_err
);
    logic             rsvd;
    logic [OUT_W-1:0] val;

    always_comb begin
        rsvd = (fmt == FMT_RIGHT_M) && (wlen == LEN_RSVD);
        val  = (mute || rsvd) ? '0 : assemble(fmt, wlen, fin_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_data   <= '0;
            right_data  <= '0;
            left_valid  <= 1'b0;
            right_valid <= 1'b0;
            len_err     <= 1'b0;
        end else begin
            len_err     <= rsvd;
            left_valid  <= fin_stb & fin_word.is_left;
            right_valid <= fin_stb & ~fin_word.is_left;
            if (fin_stb && fin_word.is_left)  left_data  <= val;
            if (fin_stb && !fin_word.is_left) right_data <= val;
        end
    end

    assert_no_dual_valid_R11: assert property (@(posedge clk) disable iff (rst)
        !(left_valid && right_valid));
    assert_mute_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (left_valid && $past(mute)) |-> (left_data == '0));
    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (right_valid && $past(fmt) == FMT_RIGHT_M && $past(wlen) == LEN_RSVD) |-> (right_data == '0));
    assert_sign_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (left_valid && $past(fmt) == FMT_RIGHT_M && $past(wlen) == LEN_16)
        |-> (left_data[OUT_W-1:16] == {(OUT_W-16){left_data[15]}}));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk,
    input  logic                wclk,
    input  logic                sdata,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wlen,
    input  logic                mute,
    output logic [SAMPLE_W-1:0] left_data,
    output logic                left_valid,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                right_valid,
    output logic                len_err
);
    logic       bit_stb, bit_val, bit_lr, fin_stb;
    slot_word_t fin_word;
    frame_fmt_e fmt_e;
    word_len_e  wlen_e;

    assign fmt_e  = frame_fmt_e'(fmt);
    assign wlen_e = word_len_e'(wlen);

    sarx_bit_front u_front (
        .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .sdata(sdata),
        .bit_stb(bit_stb), .bit_val(bit_val), .bit_lr(bit_lr)
    );

    sarx_slot_acc #(.OUT_W(SAMPLE_W), .CNT_W(SLOT_CNT_W)) u_slot (
        .clk(clk), .rst(rst), .i2s_mode(fmt_e == FMT_I2S),
        .bit_stb(bit_stb), .bit_val(bit_val), .bit_lr(bit_lr),
        .fin_stb(fin_stb), .fin_word(fin_word)
    );

    sarx_out_stage #(.OUT_W(SAMPLE_W)) u_out (
        .clk(clk), .rst(rst), .fmt(fmt_e), .wlen(wlen_e), .mute(mute),
        .fin_stb(fin_stb), .fin_word(fin_word),
        .left_data(left_data), .left_valid(left_valid),
        .right_data(right_data), .right_valid(right_valid), .len_err(len_err)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!left_valid && !right_valid && !len_err));
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0, mute = 1'b0;
    logic [1:0]  fmt = 2'd0, wlen = 2'd0;
    logic [23:0] left_data, right_data;
    logic        left_valid, right_valid, len_err;

    int vectors = 0, fails = 0, cyc = 0, last_rise = 0;
    int n_left = 0, n_right = 0, lat_left = 0, lat_right = 0;
    logic [23:0] got_left = 0, got_right = 0;
    logic dual_seen = 1'b0, finished = 1'b0;
    logic dat [0:127];
    logic lev [0:127];

    always #4 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst(rst), .bclk(bclk), .wclk(wclk), .sdata(sdata),
        .fmt(fmt), .wlen(wlen), .mute(mute),
        .left_data(left_data), .left_valid(left_valid),
        .right_data(right_data), .right_valid(right_valid), .len_err(len_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (left_valid)  begin got_left  <= left_data;  n_left  <= n_left + 1;  lat_left  <= cyc - last_rise; end
        if (right_valid) begin got_right <= right_data; n_right <= n_right + 1; lat_right <= cyc - last_rise; end
        if (left_valid && right_valid) dual_seen <= 1'b1;
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_left = 0; n_right = 0;
    endtask

    function automatic logic slot_bit(input int f, input int w, input logic [23:0] v, input int i);
        case (f)
            0, 3: return (i < w) ? v[w-1-i] : 1'b0;
            1:    return (i >= 32 - w) ? v[31-i] : 1'b1;
            default: return (i >= 8) ? v[i-8] : 1'b0;
        endcase
    endfunction

    // priming slot, left slot, right slot, two bits of the next left slot
    task automatic run_frame(input int f, input int wl, input int w,
                             input logic [23:0] lv, input logic [23:0] rv);
        logic left_lvl;
        left_lvl = (f == 3) ? 1'b0 : 1'b1;
        do_reset();
        fmt = 2'(f); wlen = 2'(wl);
        for (int j = 0; j < 98; j++) begin
            if (j < 32)      begin lev[j] = ~left_lvl; dat[j] = 1'b0; end
            else if (j < 64) begin lev[j] = left_lvl;  dat[j] = slot_bit(f, w, lv, j - 32); end
            else if (j < 96) begin lev[j] = ~left_lvl; dat[j] = slot_bit(f, w, rv, j - 64); end
            else             begin lev[j] = left_lvl;  dat[j] = 1'b0; end
        end
        lev[98] = left_lvl;
        for (int j = 0; j < 98; j++) begin
            @(negedge clk);
            bclk = 1'b0; sdata = dat[j];
            wclk = (f == 3) ? lev[j+1] : lev[j];
            repeat (4) @(negedge clk);
            bclk = 1'b1; last_rise = cyc;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 left_data", left_data, 24'h0);
        check("R1 right_data", right_data, 24'h0);
        check("R1 flags", {21'h0, left_valid, right_valid, len_err}, 24'h0);
    endtask

    task automatic t_left_just();
        run_frame(0, 2, 24, 24'hA5C30F, 24'h13579B);
        check("R2 left 24b", got_left, 24'hA5C30F);
        check("R2 right 24b", got_right, 24'h13579B);
        check("R9 left count", 24'(n_left), 24'd1);
        check("R9 right count", 24'(n_right), 24'd1);
        check("R10 left latency", 24'(lat_left), 24'd3);
        check("R10 right latency", 24'(lat_right), 24'd3);
        run_frame(0, 0, 16, 24'h008001, 24'h00FFFE);
        check("R2 left 16b aligned", got_left, 24'h800100);
        check("R2 right 16b aligned", got_right, 24'hFFFE00);
    endtask

    task automatic t_right_msb();
        run_frame(1, 0, 16, 24'h008421, 24'h001234);
        check("R3 left 16b neg", got_left, 24'hFF8421);
        check("R3 right 16b pos", got_right, 24'h001234);
        run_frame(1, 1, 20, 24'h080F0F, 24'h07ABCD);
        check("R3 left 20b", got_left, 24'hF80F0F);
        check("R3 right 20b", got_right, 24'h07ABCD);
        run_frame(1, 2, 24, 24'hC0FFEE, 24'h0BEEF1);
        check("R3 left 24b", got_left, 24'hC0FFEE);
        check("R3 right 24b", got_right, 24'h0BEEF1);
        check("R7 no err on valid code", {23'h0, len_err}, 24'h0);
    endtask

    task automatic t_right_lsb();
        run_frame(2, 0, 24, 24'h9ABCDE, 24'h123456);
        check("R4 left", got_left, 24'h9ABCDE);
        check("R4 right", got_right, 24'h123456);
    endtask

    task automatic t_i2s();
        run_frame(3, 2, 24, 24'h5A5A5B, 24'hC3C3C2);
        check("R5 left", got_left, 24'h5A5A5B);
        check("R5 right", got_right, 24'hC3C3C2);
        check("R9 i2s left count", 24'(n_left), 24'd1);
        check("R9 i2s right count", 24'(n_right), 24'd1);
    endtask

    task automatic t_len_ignored();
        run_frame(0, 3, 24, 24'h6D2E91, 24'h3F0C77);
        check("R6 left", got_left, 24'h6D2E91);
        check("R6 right", got_right, 24'h3F0C77);
        check("R6 err low", {23'h0, len_err}, 24'h0);
    endtask

    task automatic t_reserved();
        run_frame(1, 3, 24, 24'h7FFFFF, 24'h400001);
        check("R7 left zero", got_left, 24'h0);
        check("R7 right zero", got_right, 24'h0);
        check("R7 err high", {23'h0, len_err}, 24'h1);
        check("R7 left count", 24'(n_left), 24'd1);
        @(negedge clk); wlen = 2'd2;
        @(negedge clk);
        check("R7 err clears", {23'h0, len_err}, 24'h0);
    endtask

    task automatic t_mute();
        mute = 1'b1;
        run_frame(0, 2, 24, 24'hFEDCBA, 24'h765432);
        check("R8 left muted", got_left, 24'h0);
        check("R8 right muted", got_right, 24'h0);
        check("R8 pulses kept", 24'(n_left + n_right), 24'd2);
        mute = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_left_just();
        t_right_msb();
        t_right_lsb();
        t_i2s();
        t_len_ignored();
        t_reserved();
        t_mute();
        check("R11 dual valid seen", {23'h0, dual_seen}, 24'h0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule